// File: doc/BRIEF.md
# System Control and Speaker Port

This block is a one-byte control and status register that sits beside an interval timer bank. A write sets two latched controls: the count-enable (gate) of timer channel 2 and an enable that lets that channel's output through to a speaker. The gate leaves the block on its own pin and goes to the timer. The speaker pin carries channel 2's output, masked by the enable.

A read returns one status byte. It holds both latched controls, the live level of channel 2's output, and a refresh indicator. The refresh indicator is a bit inside the block that inverts at a fixed interval of 15.085 microseconds. A parameter sets that interval as a count of system clock cycles. The remaining status positions belong to parity and NMI reporting, which this block does not implement, so they read as zero.

Both strobes are synchronous. A write takes effect at the clock edge where `wr_en` is high. A read captures the status byte at the clock edge where `rd_en` is high, and `rd_data` keeps that byte until the next read.

Top module: `sysctl_port`

## Requirements
- R1: After reset, `ch2_gate` is 0, the speaker enable is 0, the refresh bit is 0, `speaker_out` is 0 and `rd_data` is 0x00.
- R2: A write with `wr_en` high loads `wr_data` bit 0 into `ch2_gate`, visible after that clock edge.
- R3: A write loads `wr_data` bit 1 into the speaker enable. `speaker_out` equals `ch2_out` AND the speaker enable at all times.
- R4: Written bits 2 to 7 have no effect on `ch2_gate`, `speaker_out` or any bit of a later read.
- R5: In the status byte, bit 0 holds the channel 2 gate and bit 1 holds the speaker enable.
- R6: Status bit 5 holds the level of `ch2_out` at the clock edge where the read is captured.
- R7: Status bit 4 is the refresh bit. It inverts every `REFRESH_HALF_CYC` clock cycles and runs freely from reset, whether or not reads happen.
- R8: Status bits 2, 3, 6 and 7 always read 0.
- R9: `rd_data` changes only after a clock edge with `rd_en` high. When a read and a write fall in the same cycle, the read returns the control values from before the write.
- R10: Without `wr_en`, `ch2_gate` and the speaker enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Control byte to write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Status byte captured by the last read |
| ch2_out | input | 1 | Output of timer channel 2 |
| ch2_gate | output | 1 | Gate for timer channel 2 |
| speaker_out | output | 1 | Channel 2 output masked by the speaker enable |

## Verification
The hardest behaviour to observe at the ports is the refresh interval. The refresh bit never appears on a pin of its own, and its phase against any single read is arbitrary. To reach it, the bench shortens the interval through the parameter and holds the read strobe high for many consecutive cycles, so the refresh bit is sampled at every edge. It then measures the spacing between successive inversions, and this spacing must equal the parameter exactly. A second hard case is a read and a write in the same cycle. The bench issues both strobes together, and the captured byte must still show the control values from before the write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned PORT_W = 8;

    // Positions inside the status byte; software decodes these.
    localparam int unsigned POS_GATE    = 0;
    localparam int unsigned POS_SPK_EN  = 1;
    localparam int unsigned POS_REFRESH = 4;
    localparam int unsigned POS_CH2_OUT = 5;

    typedef struct packed {
        logic gate;
        logic spk_en;
    } ctrl_t;

    typedef struct packed {
        logic [PORT_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/sysctl_refresh_tick.sv
module sysctl_refresh_tick #(
    parameter int unsigned HALF_CYC = 1509
) (
    input  logic clk,
    input  logic rst_n,
    output logic level
);
    localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_gate,
    input  logic  wr_spk_en,
    output ctrl_t ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.gate   = wr_gate;
            ctrl_d.spk_en = wr_spk_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/sysctl_status_rd.sv
module sysctl_status_rd
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  ctrl_t             ctrl,
    input  logic              refresh_lvl,
    input  logic              ch2_out,
    output logic [PORT_W-1:0] rd_data
);
    rd_state_t rd_d, rd_q;
    logic [PORT_W-1:0] word;

    always_comb begin
        word              = '0;
        word[POS_GATE]    = ctrl.gate;
        word[POS_SPK_EN]  = ctrl.spk_en;
        word[POS_REFRESH] = refresh_lvl;
        word[POS_CH2_OUT] = ch2_out;
        rd_d = rd_q;
        if (rd_en) rd_d.data = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.data;
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int unsigned REFRESH_HALF_CYC = 1509
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    input  logic              ch2_out,
    output logic              ch2_gate,
    output logic              speaker_out
);
    ctrl_t ctrl;
    logic  refresh_lvl;
    logic  wr_data_unused;

    assign wr_data_unused = ^wr_data[PORT_W-1:2];

    sysctl_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_gate   (wr_data[POS_GATE]),
        .wr_spk_en (wr_data[POS_SPK_EN]),
        .ctrl      (ctrl)
    );

    sysctl_refresh_tick #(.HALF_CYC(REFRESH_HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .level (refresh_lvl)
    );

    sysctl_status_rd u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .ctrl        (ctrl),
        .refresh_lvl (refresh_lvl),
        .ch2_out     (ch2_out),
        .rd_data     (rd_data)
    );

    assign ch2_gate    = ctrl.gate;
    assign speaker_out = ch2_out & ctrl.spk_en;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
    parameter int unsigned HALF = 1509
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       ch2_out,
    input logic       ch2_gate,
    input logic       speaker_out,
    input logic       refresh_lvl
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    logic [CW-1:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                          ref_cnt <= '0;
        else if (ref_cnt == CW'(HALF - 1))   ref_cnt <= '0;
        else                                 ref_cnt <= ref_cnt + 1'b1;
    end

    p_gate_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ch2_gate == $past(wr_data[0]));

    p_spk_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ch2_out |-> !speaker_out);

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:2] == 2'b00 && rd_data[7:6] == 2'b00);

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_gate_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch2_gate));

    p_refresh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt != CW'(HALF - 1)) |=> $stable(refresh_lvl));

    p_refresh_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt == CW'(HALF - 1)) |=> refresh_lvl != $past(refresh_lvl));
endmodule

bind sysctl_port sysctl_port_chk #(.HALF(REFRESH_HALF_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .ch2_out     (ch2_out),
    .ch2_gate    (ch2_gate),
    .speaker_out (speaker_out),
    .refresh_lvl (refresh_lvl)
);

// File: tb/tb_sysctl_port.sv
module tb_sysctl_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       ch2_out = 1'b0;
    logic       ch2_gate;
    logic       speaker_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_port #(.REFRESH_HALF_CYC(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ch2_out(ch2_out),
        .ch2_gate(ch2_gate), .speaker_out(speaker_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check(ch2_gate == 1'b0, "R1 gate", ch2_gate, 0);
        check(speaker_out == 1'b0, "R1 speaker", speaker_out, 0);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        do_read(v); // first edge after reset, refresh still 0
        check(v == 8'h00, "R1 status", v, 0);
    endtask

    task automatic t_gate;
        do_write(8'h01);
        check(ch2_gate == 1'b1, "R2 gate set", ch2_gate, 1);
        do_write(8'h00);
        check(ch2_gate == 1'b0, "R2 gate clear", ch2_gate, 0);
    endtask

    task automatic t_speaker;
        do_write(8'h02);
        ch2_out = 1'b1; #1;
        check(speaker_out == 1'b1, "R3 out high enabled", speaker_out, 1);
        ch2_out = 1'b0; #1;
        check(speaker_out == 1'b0, "R3 out low enabled", speaker_out, 0);
        do_write(8'h00);
        ch2_out = 1'b1; #1;
        check(speaker_out == 1'b0, "R3 out high disabled", speaker_out, 0);
        ch2_out = 1'b0;
    endtask

    task automatic t_ignored_bits;
        logic [7:0] v;
        do_write(8'hFC);
        check(ch2_gate == 1'b0, "R4 gate", ch2_gate, 0);
        ch2_out = 1'b1; #1;
        check(speaker_out == 1'b0, "R4 speaker", speaker_out, 0);
        ch2_out = 1'b0;
        do_read(v);
        check((v & 8'hEF) == 8'h00, "R4 status", v & 8'hEF, 0);
        check((v & 8'hCC) == 8'h00, "R8 reserved", v & 8'hCC, 0);
    endtask

    task automatic t_read_ctrl;
        logic [7:0] v;
        do_write(8'h03);
        do_read(v);
        check((v & 8'h03) == 8'h03, "R5 both set", v & 8'h03, 3);
        do_write(8'h02);
        do_read(v);
        check((v & 8'h03) == 8'h02, "R5 enable only", v & 8'h03, 2);
        check((v & 8'hCC) == 8'h00, "R8 reserved", v & 8'hCC, 0);
        do_write(8'h01);
        do_read(v);
        check((v & 8'h03) == 8'h01, "R5 gate only", v & 8'h03, 1);
    endtask

    task automatic t_out2;
        logic [7:0] v;
        ch2_out = 1'b1;
        do_read(v);
        check(v[5] == 1'b1, "R6 out high", v[5], 1);
        ch2_out = 1'b0;
        do_read(v);
        check(v[5] == 1'b0, "R6 out low", v[5], 0);
    endtask

    task automatic t_refresh;
        int last_change = -1;
        int changes = 0;
        logic prev;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk);
        prev = rd_data[4];
        for (int i = 1; i <= 6 * HALF; i++) begin
            @(negedge clk);
            check((rd_data & 8'hCC) == 8'h00, "R8 reserved live", rd_data & 8'hCC, 0);
            if (rd_data[4] != prev) begin
                if (last_change >= 0)
                    check(i - last_change == HALF, "R7 interval", i - last_change, HALF);
                last_change = i;
                changes++;
                prev = rd_data[4];
            end
        end
        rd_en = 1'b0;
        check(changes >= 5, "R7 toggle count", changes, 5);
    endtask

    task automatic t_hold_and_collide;
        logic [7:0] v;
        logic [7:0] held;
        do_write(8'h00);
        do_read(held);
        do_write(8'h03);
        repeat (2 * HALF) @(negedge clk);
        check(rd_data == held, "R9 hold", rd_data, held);
        check(ch2_gate == 1'b1, "R10 keep gate", ch2_gate, 1);
        do_read(v);
        check((v & 8'h03) == 8'h03, "R10 keep enable", v & 8'h03, 3);
        @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        check((rd_data & 8'h03) == 8'h03, "R9 read before write", rd_data & 8'h03, 3);
        check(ch2_gate == 1'b0, "R9 write applied", ch2_gate, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_speaker();
        t_ignored_bits();
        t_read_ctrl();
        t_out2();
        t_refresh();
        t_hold_and_collide();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule